// File: doc/BRIEF.md
# MSI Vector Interrupt Multiplexer

This block sits between the inbound write path of a PCIe root port and the host interrupt controller. Each inbound message-signalled interrupt arrives as a write whose data is a vector number. The block records each vector as a pending bit and folds the 32 vectors onto 8 level-sensitive host interrupt lines. The folding is interleaved: vector `v` belongs to group `v mod 8` and occupies bit `v div 8` of that group. Vectors 0, 8, 16 and 24 therefore share line 0, and vectors 1, 9, 17 and 25 share line 1.

Software services a line through a small register bus. For each group there is a pending-status register, an enable-set register and an enable-clear register. The handler reads the status register and clears the bits it has handled by writing ones to them. It then writes an end-of-interrupt code, equal to the group number plus 4, to a shared register. A group's line, once it has dropped, stays low until that code arrives, even if new vectors become pending in the meantime. After the code arrives, the line is driven high again if any enabled bit is still pending.

Top module: `msi_vector_mux`

## Requirements
- R1: An inbound write to offset 0x054 carrying data `v` in the range 0 to 31 sets bit `v >> 3` of the pending status of group `v & 7`. All other status bits are left unchanged.
- R2: A software read of offset 0x104 + 16*k returns the 4 pending bits of group k in bits 3:0. Bits 31:4 read as zero.
- R3: A software write to offset 0x104 + 16*k clears every pending bit of group k whose written data bit is 1. Bits written as 0 keep their value.
- R4: A write to offset 0x108 + 16*k sets the enable bits of group k that are written as 1. A write to 0x10C + 16*k clears the enable bits of group k that are written as 1. Zero bits have no effect in either case. A read of either offset returns the group's 4 enable bits in bits 3:0, with bits 31:4 zero.
- R5: `irq[k]` is high while group k has at least one bit that is both pending and enabled, and no end-of-interrupt is owed for that group.
- R6: Once `irq[k]` falls, an end-of-interrupt is owed for group k, and `irq[k]` stays low whatever becomes pending. A software write of data k + 4 to offset 0x050 settles the debt. The line then goes high again if enabled bits are still pending.
- R7: If an inbound vector and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Inbound data of 32 or more, and inbound writes to any offset other than 0x054, change no status bit.
- R9: After reset, all status and enable bits are zero, no end-of-interrupt is owed, and every `irq` line is low.
- R10: A write to offset 0x050 whose data is not in the range 4 to 11 settles no group's debt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_addr | input | 12 | Software register byte offset (write and read) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data for `sw_addr`, combinational |
| in_wr | input | 1 | Inbound message write strobe |
| in_addr | input | 12 | Inbound write byte offset |
| in_wdata | input | 32 | Inbound write data (vector number) |
| irq | output | 8 | Level interrupt line per group |

## Verification
The bench builds the block with its default parameters: 8 groups of 4 bits. At this size every one of the 32 vectors can be swept in turn. Each vector goes through the full cycle of pending, enable, clear, re-posting while the end-of-interrupt is owed, settling the debt, and disabling. An arithmetic model of status, enable and the owed flag is compared against every status read, every enable read and all 8 lines after each operation. The same small size also makes it practical to try the out-of-range vectors, the collision between a new vector and a clear, and the end-of-interrupt codes just outside the valid range.

// File: rtl/msi_mux_pkg.sv
package msi_mux_pkg;
  // Byte offsets in the register space
  localparam int unsigned OFS_EOI      = 32'h050;
  localparam int unsigned OFS_MSI      = 32'h054;
  localparam int unsigned OFS_GRP_BASE = 32'h100;
  localparam int unsigned GRP_STRIDE   = 16;
  localparam int unsigned SLOT_STATUS  = 4;
  localparam int unsigned SLOT_ENSET   = 8;
  localparam int unsigned SLOT_ENCLR   = 12;

  // Interleaved fold: consecutive vectors land in consecutive groups
  function automatic int unsigned vec_group(int unsigned v, int unsigned ngrp);
    return v % ngrp;
  endfunction

  function automatic int unsigned vec_slot(int unsigned v, int unsigned ngrp);
    return v / ngrp;
  endfunction

  function automatic int unsigned grp_reg(int unsigned g, int unsigned slot);
    return OFS_GRP_BASE + g * GRP_STRIDE + slot;
  endfunction
endpackage

// File: rtl/msi_mux_inbound.sv
module msi_mux_inbound
  import msi_mux_pkg::*;
#(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned NBIT   = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   in_wr,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [DATA_W-1:0]      in_wdata,
  output logic [NGRP*NBIT-1:0]   set_flat
);
  localparam int unsigned NVEC = NGRP * NBIT;

  logic msi_hit;
  assign msi_hit = in_wr && (in_addr == ADDR_W'(OFS_MSI));

  // One comparator per vector; data outside 0..NVEC-1 matches none
  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    localparam int unsigned IDX = vec_group(v, NGRP) * NBIT + vec_slot(v, NGRP);
    assign set_flat[IDX] = msi_hit && (in_wdata == DATA_W'(v));
  end
endmodule

// File: rtl/msi_mux_regdec.sv
module msi_mux_regdec
  import msi_mux_pkg::*;
#(
  parameter int unsigned NGRP     = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EOI_BIAS = 4
) (
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [NGRP-1:0]   sel_stat,
  output logic [NGRP-1:0]   sel_eset,
  output logic [NGRP-1:0]   sel_eclr,
  output logic [NGRP-1:0]   eoi_hit
);
  logic eoi_wr;
  assign eoi_wr = sw_wr && (sw_addr == ADDR_W'(OFS_EOI));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign sel_stat[g] = (sw_addr == ADDR_W'(grp_reg(g, SLOT_STATUS)));
    assign sel_eset[g] = (sw_addr == ADDR_W'(grp_reg(g, SLOT_ENSET)));
    assign sel_eclr[g] = (sw_addr == ADDR_W'(grp_reg(g, SLOT_ENCLR)));
    assign eoi_hit[g]  = eoi_wr && (sw_wdata == DATA_W'(g + EOI_BIAS));
  end
endmodule

// File: rtl/msi_mux_group.sv
module msi_mux_group #(
  parameter int unsigned NBIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBIT-1:0] set_bits,
  input  logic [NBIT-1:0] clr_bits,
  input  logic [NBIT-1:0] eset_bits,
  input  logic [NBIT-1:0] eclr_bits,
  input  logic            eoi,
  output logic [NBIT-1:0] status,
  output logic [NBIT-1:0] enable,
  output logic            irq
);
  logic owed;
  logic line_q;
  logic active;

  assign active = |(status & enable);
  assign irq    = active && !owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      owed   <= 1'b0;
      line_q <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | set_bits;   // a new vector beats a clear
      enable <= (enable | eset_bits) & ~eclr_bits;
      owed   <= eoi ? 1'b0 : (owed | (line_q & ~active));
      line_q <= irq;
    end
  end
endmodule

// File: rtl/msi_vector_mux.sv
module msi_vector_mux #(
  parameter int unsigned NGRP     = 8,
  parameter int unsigned NBIT     = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EOI_BIAS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [NGRP-1:0]   irq
);
  localparam int unsigned NVEC = NGRP * NBIT;

  logic [NVEC-1:0] set_flat;
  logic [NVEC-1:0] clr_flat;
  logic [NVEC-1:0] eset_flat;
  logic [NVEC-1:0] eclr_flat;
  logic [NVEC-1:0] status_flat;
  logic [NVEC-1:0] enable_flat;
  logic [NGRP-1:0] sel_stat, sel_eset, sel_eclr, eoi_hit;

  msi_mux_inbound #(.NGRP(NGRP), .NBIT(NBIT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_inbound (
    .in_wr(in_wr), .in_addr(in_addr), .in_wdata(in_wdata), .set_flat(set_flat)
  );

  msi_mux_regdec #(.NGRP(NGRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EOI_BIAS(EOI_BIAS)) u_regdec (
    .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sel_stat(sel_stat), .sel_eset(sel_eset), .sel_eclr(sel_eclr), .eoi_hit(eoi_hit)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign clr_flat[g*NBIT +: NBIT]  = sw_wdata[NBIT-1:0] & {NBIT{sw_wr && sel_stat[g]}};
    assign eset_flat[g*NBIT +: NBIT] = sw_wdata[NBIT-1:0] & {NBIT{sw_wr && sel_eset[g]}};
    assign eclr_flat[g*NBIT +: NBIT] = sw_wdata[NBIT-1:0] & {NBIT{sw_wr && sel_eclr[g]}};

    msi_mux_group #(.NBIT(NBIT)) u_group (
      .clk(clk), .rst_n(rst_n),
      .set_bits(set_flat[g*NBIT +: NBIT]),
      .clr_bits(clr_flat[g*NBIT +: NBIT]),
      .eset_bits(eset_flat[g*NBIT +: NBIT]),
      .eclr_bits(eclr_flat[g*NBIT +: NBIT]),
      .eoi(eoi_hit[g]),
      .status(status_flat[g*NBIT +: NBIT]),
      .enable(enable_flat[g*NBIT +: NBIT]),
      .irq(irq[g])
    );
  end

  always_comb begin
    sw_rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (sel_stat[g])
        sw_rdata = sw_rdata | DATA_W'(status_flat[g*NBIT +: NBIT]);
      if (sel_eset[g] || sel_eclr[g])
        sw_rdata = sw_rdata | DATA_W'(enable_flat[g*NBIT +: NBIT]);
    end
  end
endmodule

// File: rtl/msi_vector_mux_checker.sv
module msi_vector_mux_checker #(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned NBIT   = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_wr,
  input logic                 in_wr,
  input logic [DATA_W-1:0]    in_wdata,
  input logic [NGRP-1:0]      irq,
  input logic [NGRP-1:0]      eoi_hit,
  input logic [NGRP*NBIT-1:0] set_flat,
  input logic [NGRP*NBIT-1:0] clr_flat,
  input logic [NGRP*NBIT-1:0] eset_flat,
  input logic [NGRP*NBIT-1:0] eclr_flat,
  input logic [NGRP*NBIT-1:0] status_flat,
  input logic [NGRP*NBIT-1:0] enable_flat
);
  localparam int unsigned NVEC = NGRP * NBIT;

  for (genvar i = 0; i < NVEC; i++) begin : g_bit
    assert_msi_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_flat[i] |=> status_flat[i]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flat[i] && !set_flat[i]) |=> !status_flat[i]);
    assert_enset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eset_flat[i] && !eclr_flat[i]) |=> enable_flat[i]);
    assert_enclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eclr_flat[i] |=> !enable_flat[i]);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_line
    assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq[g]) && !eoi_hit[g]) |=> !irq[g]);
  end

  assert_bad_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && in_wdata >= DATA_W'(NVEC) && !sw_wr) |=> (status_flat == $past(status_flat)));
endmodule

bind msi_vector_mux msi_vector_mux_checker #(.NGRP(NGRP), .NBIT(NBIT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .in_wr(in_wr), .in_wdata(in_wdata),
  .irq(irq), .eoi_hit(eoi_hit), .set_flat(set_flat), .clr_flat(clr_flat),
  .eset_flat(eset_flat), .eclr_flat(eclr_flat),
  .status_flat(status_flat), .enable_flat(enable_flat)
);

// File: tb/msi_vector_mux_tb.sv
module msi_vector_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [11:0] sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        in_wr = 1'b0;
  logic [11:0] in_addr = '0;
  logic [31:0] in_wdata = '0;
  logic [7:0]  irq;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_st [8];
  logic [3:0] m_en [8];
  logic       m_owed [8];

  always #2 clk = ~clk;   // 250 MHz

  msi_vector_mux u_dut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .in_wr(in_wr), .in_addr(in_addr), .in_wdata(in_wdata), .irq(irq)
  );

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int g = 0; g < 8; g++) r[g] = (|(m_st[g] & m_en[g])) && !m_owed[g];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int g = 0; g < 8; g++) begin
      sw_addr = 12'(32'h104 + 16 * g); #0.5;
      chk(sw_rdata == {28'd0, m_st[g]}, req, sw_rdata, {28'd0, m_st[g]});
      sw_addr = 12'(32'h108 + 16 * g); #0.5;
      chk(sw_rdata == {28'd0, m_en[g]}, req, sw_rdata, {28'd0, m_en[g]});
    end
    chk(irq == exp_irq(), req, {24'd0, irq}, {24'd0, exp_irq()});
  endtask

  // One write cycle (software, inbound, or both) followed by one idle cycle
  task automatic op(input bit dsw, input logic [11:0] a, input logic [31:0] d,
                    input bit din, input logic [11:0] ia, input logic [31:0] id);
    logic [7:0] l0;
    l0 = exp_irq();
    @(negedge clk);
    sw_wr = dsw; sw_addr = a; sw_wdata = d; in_wr = din; in_addr = ia; in_wdata = id;
    @(negedge clk);
    sw_wr = 1'b0; in_wr = 1'b0;
    @(negedge clk);
    for (int g = 0; g < 8; g++) begin
      logic [3:0] setb, clrb, esb, ecb;
      logic eoi;
      setb = '0; clrb = '0; esb = '0; ecb = '0; eoi = 1'b0;
      if (din && ia == 12'h054 && id < 32 && (id & 7) == g) setb[id >> 3] = 1'b1;
      if (dsw && a == 12'(32'h104 + 16 * g)) clrb = d[3:0];
      if (dsw && a == 12'(32'h108 + 16 * g)) esb  = d[3:0];
      if (dsw && a == 12'(32'h10C + 16 * g)) ecb  = d[3:0];
      if (dsw && a == 12'h050 && d == 32'(g + 4)) eoi = 1'b1;
      m_st[g] = (m_st[g] & ~clrb) | setb;
      m_en[g] = (m_en[g] | esb) & ~ecb;
      m_owed[g] = (eoi ? 1'b0 : m_owed[g]) | (l0[g] && !(|(m_st[g] & m_en[g])));
    end
  endtask

  task automatic sw(input logic [11:0] a, input logic [31:0] d);
    op(1'b1, a, d, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic msi(input logic [31:0] v);
    op(1'b0, 12'h0, 32'h0, 1'b1, 12'h054, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int g = 0; g < 8; g++) begin m_st[g] = '0; m_en[g] = '0; m_owed[g] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");
    for (int g = 0; g < 8; g++) begin
      sw_addr = 12'(32'h10C + 16 * g); #0.5;
      chk(sw_rdata == 32'd0, "R9", sw_rdata, 32'd0);
    end

    // Sweep every vector through the service cycle
    for (int v = 0; v < 32; v++) begin
      int g, b;
      g = v % 8; b = v / 8;
      msi(32'(v));                                   check_all("R1");
      sw(12'(32'h108 + 16 * g), 32'(1 << b));        check_all("R5");
      chk(irq == 8'(1 << g), "R5", {24'd0, irq}, 32'(1 << g));
      sw(12'(32'h104 + 16 * g), 32'(1 << b));        check_all("R3");
      msi(32'(v));                                   check_all("R6");
      chk(irq == 8'd0, "R6", {24'd0, irq}, 32'd0);
      sw(12'h050, 32'(g + 4));                       check_all("R6");
      chk(irq == 8'(1 << g), "R6", {24'd0, irq}, 32'(1 << g));
      sw(12'(32'h104 + 16 * g), 32'(1 << b));
      sw(12'h050, 32'(g + 4));                       check_all("R6");
      sw(12'(32'h10C + 16 * g), 32'(1 << b));
      sw_addr = 12'(32'h10C + 16 * g); #0.5;
      chk(sw_rdata == 32'd0, "R4", sw_rdata, 32'd0);
      check_all("R4");
    end

    // Full group, upper bits zero
    msi(3); msi(11); msi(19); msi(27);
    sw_addr = 12'h134; #0.5;
    chk(sw_rdata == 32'h0000_000F, "R2", sw_rdata, 32'hF);
    check_all("R2");
    sw(12'h134, 32'h0);                              check_all("R3");
    sw(12'h134, 32'hFFFF_FFF5);                      check_all("R3");

    // Enable writes of zero and partial clears
    sw(12'h128, 32'h0000_000A);                      check_all("R4");
    sw(12'h128, 32'h0);  sw(12'h12C, 32'h0);         check_all("R4");
    sw_addr = 12'h12C; #0.5;
    chk(sw_rdata == 32'h0000_000A, "R4", sw_rdata, 32'hA);
    sw(12'h12C, 32'h0000_0008);                      check_all("R4");

    // Ignored inbound traffic
    msi(32); msi(40); msi(255); msi(32'hFFFF_FFFF);
    op(1'b0, 12'h0, 32'h0, 1'b1, 12'h058, 32'd5);
    op(1'b0, 12'h0, 32'h0, 1'b1, 12'h050, 32'd6);    check_all("R8");

    // New vector and clear of the same bit in one cycle
    msi(9);
    op(1'b1, 12'h114, 32'h2, 1'b1, 12'h054, 32'd9);  check_all("R7");
    sw_addr = 12'h114; #0.5;
    chk(sw_rdata[1] == 1'b1, "R7", sw_rdata, 32'h2);
    op(1'b1, 12'h114, 32'h2, 1'b1, 12'h054, 32'd17); check_all("R7");

    // Out-of-range end-of-interrupt codes
    sw(12'h128, 32'h1);  msi(2);                     check_all("R5");
    sw(12'h124, 32'h1);  msi(2);                     check_all("R10");
    sw(12'h050, 32'd3);  sw(12'h050, 32'd12);
    sw(12'h050, 32'd2);  sw(12'h050, 32'd0);         check_all("R10");
    chk(irq[2] == 1'b0, "R10", {31'd0, irq[2]}, 32'd0);
    sw(12'h050, 32'd6);                              check_all("R10");
    chk(irq[2] == 1'b1, "R10", {31'd0, irq[2]}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule